// File: doc/BRIEF.md
# Clocked Serial Byte Transmitter

This block sends bytes over a clocked synchronous serial link in which it is the clock master. A byte offered on a valid/ready input is kept in a one-byte holding buffer. The byte then moves into a shift register and leaves on the serial data output, least significant bit first, one bit per shift-clock period. The shift clock comes from a two-stage divider. A prescaler picks the undivided system clock, the clock divided by 8 or the clock divided by 32 as the count source. A programmable counter then divides that source down to one half period of the shift clock.

The shift clock idles high. The data line changes only on falling clock edges, so a receiver samples it on rising edges. The shift clock pulses only while the clear-to-send input is low and transmit is enabled. Dropping either one freezes the clock at its present level and the current bit, and the byte carries on when the gate opens again. When the holding buffer already has the next byte at the end of the current one, the two bytes go out with no idle clock time between them. Otherwise the clock rests high between bytes.

On the input side, a byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when the holding buffer is empty. An upstream source that sees `in_ready` low must hold its byte until `in_ready` returns high. The block has a buffer-empty output, a shifter-empty output and an interrupt request with acknowledge.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset `sclk` is 1, `sdo` is 1, `in_ready` is 1, `shift_empty` is 1 and `irq` is 0.
- R2: While a byte is shifting with the gate open, falling edges of `sclk` are 2·(div_val+1)·P system clocks apart. P is 1 for `src_sel`=0, 8 for `src_sel`=1, and 32 for `src_sel`=2 or 3.
- R3: Each byte leaves on `sdo` as eight bits, bit 0 first and bit 7 last, with one bit per `sclk` period. `sdo` changes only in the cycle where `sclk` falls, and `sclk` is 1 whenever the shifter is empty.
- R4: A byte is accepted only on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 exactly when the holding buffer is empty. A byte offered while `in_ready` is 0 is dropped and never sent.
- R5: A held byte moves into the shift register on the first clock edge where the shifter is idle and `tx_en` is 1. `in_ready` returns to 1 at that edge.
- R6: If the holding buffer is full when the last bit of a byte completes, the next byte follows with no gap. Across two such bytes, the last rising `sclk` edge comes 31·(div_val+1)·P clocks after the first falling edge.
- R7: While `cts_n` is 1, `sclk` does not change. Pulsing resumes when `cts_n` returns to 0, and no bit is lost or repeated.
- R8: While `tx_en` is 0, `sclk` does not change and no held byte is moved into the shift register.
- R9: `shift_empty` is 1 exactly when no byte is shifting and none is held.
- R10: `irq` goes to 1 on the edge where a held byte moves to the shift register. It goes to 0 on the edge after `irq_ack` is 1, unless another transfer happens on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; gates clock pulses and buffer transfers |
| cts_n | input | 1 | Clear-to-send, active low; high pauses the shift clock |
| src_sel | input | 2 | Count source: 0 = clk, 1 = clk/8, 2 or 3 = clk/32 |
| div_val | input | DIV_W (8) | Divider setting n; half period is n+1 source ticks |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` holds a byte to send |
| in_ready | output | 1 | Holding buffer empty; doubles as the buffer-empty status |
| sclk | output | 1 | Shift clock, idles high |
| sdo | output | 1 | Serial data, LSB first |
| shift_empty | output | 1 | Nothing shifting and nothing held |
| irq | output | 1 | Transmit interrupt request |
| irq_ack | input | 1 | Clears `irq` |

## Verification
The bench covers every count source against several divider settings, each time with two bytes back to back. A divider that was off by one, or a prescaler on the wrong tap, would show up as a wrong spacing between falling edges or a wrong span across the byte pair. A shifter that reloaded late at a byte boundary would add an idle half period, which the span check catches. The bench stops the clock mid-byte with clear-to-send and with transmit enable and checks that `sclk` stays still and that the byte still arrives intact. It holds a byte with transmit disabled and offers a second byte that must be dropped, so a design that accepted writes into a full buffer, or moved a byte while disabled, sends the wrong data or the wrong number of bytes. Every `sdo` change must line up with a falling `sclk`, so data changing on the wrong edge is flagged at once.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic [1:0] {
    SRC_DIV1  = 2'd0,
    SRC_DIV8  = 2'd1,
    SRC_DIV32 = 2'd2
  } src_sel_e;

  localparam int unsigned PRE_W = 5;  // wide enough for divide-by-32
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/sst_prescale.sv
module sst_prescale
  import sst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       src_tick
);
  logic [PRE_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  always_comb begin
    unique case (sel)
      SRC_DIV1: src_tick = 1'b1;
      SRC_DIV8: src_tick = (cnt[2:0] == 3'd7);
      default:  src_tick = (cnt == {PRE_W{1'b1}});
    endcase
  end
endmodule

// File: rtl/sst_divider.sv
module sst_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] div_val,
  output logic             half_tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap      = (cnt == div_val);
  assign half_tick = run & src_tick & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (src_tick) cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/sst_core.sv
module sst_core
  import sst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              half_tick,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              irq_ack,
  output logic              in_ready,
  output logic              busy,
  output logic              sclk,
  output logic              sdo,
  output logic              shift_empty,
  output logic              irq
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] hold_q, shift_q;
  logic              hold_full;
  logic [CNT_W-1:0]  bit_idx;
  logic              accept, last_rise, load;

  assign accept      = in_valid & ~hold_full;
  assign last_rise   = half_tick & ~sclk & (bit_idx == CNT_W'(BYTE_W - 1));
  assign load        = tx_en & hold_full & (~busy | last_rise);
  assign in_ready    = ~hold_full;
  assign shift_empty = ~busy & ~hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (accept) begin
      hold_q    <= in_data;
      hold_full <= 1'b1;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      busy    <= 1'b0;
      bit_idx <= '0;
      sclk    <= 1'b1;
      sdo     <= 1'b1;
    end else begin
      if (half_tick) begin
        if (sclk) begin
          sclk <= 1'b0;
          sdo  <= shift_q[bit_idx];
        end else begin
          sclk    <= 1'b1;
          bit_idx <= bit_idx + 1'b1;
          if (bit_idx == CNT_W'(BYTE_W - 1)) busy <= 1'b0;
        end
      end
      if (load) begin
        shift_q <= hold_q;
        busy    <= 1'b1;
        bit_idx <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (load)    irq <= 1'b1;
    else if (irq_ack) irq <= 1'b0;
  end
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import sst_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             cts_n,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             sclk,
  output logic             sdo,
  output logic             shift_empty,
  output logic             irq,
  input  logic             irq_ack
);
  logic src_tick, half_tick, busy, run;

  assign run = busy & tx_en & ~cts_n;

  sst_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .sel(src_sel), .src_tick(src_tick)
  );

  sst_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .src_tick(src_tick),
    .div_val(div_val), .half_tick(half_tick)
  );

  sst_core u_core (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .half_tick(half_tick),
    .in_valid(in_valid), .in_data(in_data), .irq_ack(irq_ack),
    .in_ready(in_ready), .busy(busy), .sclk(sclk), .sdo(sdo),
    .shift_empty(shift_empty), .irq(irq)
  );
endmodule

// File: rtl/sst_checks.sv
module sst_checks (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic cts_n,
  input logic sclk,
  input logic sdo,
  input logic in_ready,
  input logic shift_empty,
  input logic irq,
  input logic irq_ack
);
  // R3: data moves only together with a falling shift clock
  a_r3_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $fell(sclk));

  // R3 / R9: shift clock rests high whenever nothing is queued or shifting
  a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> sclk);

  // R7, R8: a closed gate freezes the shift clock
  a_r7_gate_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_n || !tx_en) |=> $stable(sclk));

  // R10: request rises only when the holding buffer empties
  a_r10_irq_on_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $rose(in_ready));

  // R10: acknowledge clears the request unless a new transfer coincides
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !in_ready && !tx_en) |=> !irq);
endmodule

bind sync_ser_tx sst_checks u_sst_checks (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cts_n(cts_n), .sclk(sclk),
  .sdo(sdo), .in_ready(in_ready), .shift_empty(shift_empty), .irq(irq),
  .irq_ack(irq_ack)
);

// File: tb/sync_ser_tx_bench.sv
`timescale 1ns/1ps
module sync_ser_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       cts_n = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic [7:0] div_val = 8'd0;
  logic [7:0] in_data = 8'd0;
  logic       in_valid = 1'b0;
  logic       irq_ack = 1'b0;
  logic       in_ready, sclk, sdo, shift_empty, irq;

  sync_ser_tx u_sync_ser_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cts_n(cts_n),
    .src_sel(src_sel), .div_val(div_val), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .sclk(sclk), .sdo(sdo),
    .shift_empty(shift_empty), .irq(irq), .irq_ack(irq_ack)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // line monitor, sampling at the falling clk edge
  logic [7:0] rx [0:63];
  int   nrx = 0, nb = 0, edges = 0;
  logic [7:0] sh = 0;
  logic psclk = 1'b1, psdo = 1'b1;
  bit   per_on = 0, lf_v = 0;
  int   exp_per = 0, last_fall = 0, first_fall = -1, last_rise = 0;

  always @(negedge clk) if (rst_n) begin
    if (sclk !== psclk) begin
      edges++;
      if (!sclk) begin
        if (per_on && lf_v)
          chk(cyc - last_fall == exp_per, "R2 R6 fall spacing", cyc - last_fall, exp_per);
        if (first_fall < 0) first_fall = cyc;
        last_fall = cyc;
        lf_v = 1;
      end else begin
        last_rise = cyc;
        sh = {sdo, sh[7:1]};
        nb++;
        if (nb == 8) begin
          rx[nrx] = sh;
          nrx++;
          nb = 0;
        end
      end
    end
    if (sdo !== psdo && !(psclk && !sclk))
      chk(0, "R3 sdo moved off falling edge", int'(sdo), int'(psdo));
    psclk = sclk;
    psdo  = sdo;
  end

  task automatic send(input logic [7:0] b);
    do @(negedge clk); while (!in_ready);
    in_data  = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    do begin @(negedge clk); n++; end while (!shift_empty && n < 20000);
    repeat (3) @(negedge clk);
  endtask

  function automatic int src_div(input int s);
    return (s == 0) ? 1 : (s == 1) ? 8 : 32;
  endfunction

  initial begin
    #1_500_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base, e0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sclk === 1'b1, "R1 sclk", int'(sclk), 1);
    chk(sdo === 1'b1, "R1 sdo", int'(sdo), 1);
    chk(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(shift_empty === 1'b1, "R1 shift_empty", int'(shift_empty), 1);
    chk(irq === 1'b0, "R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 / R4 / R5 / R10: byte held while disabled, extra offer dropped
    base = nrx;
    send(8'hA6);
    repeat (40) @(negedge clk);
    chk(in_ready === 1'b0, "R8 byte still held", int'(in_ready), 0);
    chk(shift_empty === 1'b0, "R9 not empty while held", int'(shift_empty), 0);
    chk(edges == 0, "R8 no clock while disabled", edges, 0);
    chk(irq === 1'b0, "R8 no transfer while disabled", int'(irq), 0);
    in_data = 8'hFF; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    tx_en = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R5 buffer freed on enable", int'(in_ready), 1);
    chk(irq === 1'b1, "R10 irq set on transfer", int'(irq), 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk(irq === 1'b0, "R10 irq cleared by ack", int'(irq), 0);
    wait_idle();
    chk(nrx - base == 1, "R4 full-buffer offer dropped", nrx - base, 1);
    chk(rx[base] == 8'hA6, "R4 R3 held byte sent", int'(rx[base]), 'hA6);
    chk(shift_empty === 1'b1, "R9 empty after send", int'(shift_empty), 1);

    // R2 / R3 / R6 sweep over count source and divider
    for (int s = 0; s < 3; s++) begin
      for (int d = 0; d < 4; d++) begin
        logic [7:0] b0, b1;
        b0 = 8'h5A ^ 8'(s * 37 + d * 11);
        b1 = ~b0 ^ 8'(d);
        src_sel = 2'(s);
        div_val = 8'(d);
        exp_per = 2 * (d + 1) * src_div(s);
        lf_v = 0; first_fall = -1; per_on = 1;
        base = nrx;
        send(b0);
        send(b1);
        wait_idle();
        per_on = 0;
        chk(nrx - base == 2, "R3 two bytes out", nrx - base, 2);
        chk(rx[base] == b0, "R3 first byte LSB first", int'(rx[base]), int'(b0));
        chk(rx[base+1] == b1, "R3 second byte LSB first", int'(rx[base+1]), int'(b1));
        chk(last_rise - first_fall == 31 * (d + 1) * src_div(s),
            "R6 no gap between bytes", last_rise - first_fall, 31 * (d + 1) * src_div(s));
        chk(irq === 1'b1, "R10 irq pending", int'(irq), 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
      end
    end

    // R7 / R8 mid-byte pauses
    src_sel = 2'd0; div_val = 8'd2;
    base = nrx;
    send(8'hC3);
    e0 = edges;
    while (edges < e0 + 5) @(negedge clk);
    cts_n = 1'b1;
    @(negedge clk);
    e0 = edges;
    repeat (50) @(negedge clk);
    chk(edges == e0, "R7 clock frozen by cts_n", edges - e0, 0);
    chk(shift_empty === 1'b0, "R9 busy during pause", int'(shift_empty), 0);
    cts_n = 1'b0;
    while (edges < e0 + 4) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    e0 = edges;
    repeat (50) @(negedge clk);
    chk(edges == e0, "R8 clock frozen by tx_en", edges - e0, 0);
    tx_en = 1'b1;
    wait_idle();
    chk(nrx - base == 1, "R7 one byte after pauses", nrx - base, 1);
    chk(rx[base] == 8'hC3, "R7 byte intact after pauses", int'(rx[base]), 'hC3);
    chk(sclk === 1'b1, "R3 clock idles high", int'(sclk), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule